// File: doc/BRIEF.md
# Two-Channel Double-Buffered Control Register Bank

This block holds the control state of a two-channel waveform generator core. A byte-wide port carries writes and reads with an address. Three global registers sit at fixed addresses: a channel gate register, a 24-bit configuration word and a 16-bit configuration word. A set of 32-bit registers is replicated once per channel. A write to a per-channel address lands in every channel whose gate bit is currently set. To give the channels different values, software opens one gate, writes, then opens the other gate and writes again.

The gate bits act at once. Every other bit goes first into a shadow copy. It is copied into the active copy, which drives the exported outputs, only after an update strobe. Multi-byte registers are loaded most significant byte first. The shadow changes only when the last byte of a register arrives. A read returns one byte of either the shadow or the active copy. For per-channel addresses, the byte comes from the single channel whose gate is open.

Top module: `dds_regbank`

## Requirements
- R1: After synchronous reset both gate bits are 1 and the gate register reads 0xF0 from either copy. The active configuration words and all active channel registers are zero, and `rd_valid` and `rd_err` are low.
- R2: Address 0x00 is the gate register. Bit 7 gates channel 1 and bit 6 gates channel 0. A write there changes `chan_en` at the next clock edge with no update strobe, and `chan_en` reads back in bits 7:6.
- R3: Gate register bits 5:0, the 24-bit word at 0x01 and the 16-bit word at 0x02 change only their shadow copy on a write. Their active copy and exported outputs stay unchanged until an update.
- R4: `io_update` is registered. When it is high at clock edge k, every active copy of every register in both channels takes the shadow value at edge k+1.
- R5: A completed write to a per-channel address (0x04 and 0x05, 32 bits each) updates that register's shadow in every channel whose gate bit is 1 and leaves gated-off channels untouched.
- R6: A register of N bytes (gate 1, 0x01 3, 0x02 2, per-channel 4) is loaded by N consecutive writes to its address, most significant byte first. Its shadow changes only on the N-th write.
- R7: A write to a different address abandons a partly loaded register. Loading starts over at that new address, and the abandoned register keeps its old value.
- R8: `rd_en` gives `rdata` and `rd_valid` one cycle later. `rd_active`=0 selects the shadow copy and 1 the active copy. `rd_byte`=0 selects the least significant byte, and bytes beyond a register's width read 0.
- R9: A read of a per-channel address while zero or both gate bits are set returns 0x00 and raises `rd_err` for that one read cycle.
- R10: Address 0x03 and addresses at 0x06 and above read 0x00. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read request |
| rd_active | input | 1 | Read source: 0 shadow, 1 active |
| rd_byte | input | 2 | Byte index of the read, 0 = least significant |
| io_update | input | 1 | Shadow-to-active transfer strobe |
| rdata | output | 8 | Read byte, registered |
| rd_valid | output | 1 | Read data valid |
| rd_err | output | 1 | Per-channel read with no unique gate open |
| chan_en | output | 2 | Live channel gate bits |
| mode_act | output | 6 | Active gate-register bits 5:0 |
| fr1_act | output | 24 | Active 24-bit configuration word |
| fr2_act | output | 16 | Active 16-bit configuration word |
| ch_act | output | 128 | Active channel registers, channel c register r at bits (2c+r)*32 |

## Verification
The hardest condition to reach is two channels holding different shadow values for the same register. Only the gated write protocol produces it. The stimulus opens the gate for channel 1 alone, loads a word, then reopens the gate for channel 0 alone and reads both back before any update. A second hard condition is an abandoned partial load. The stimulus interleaves two bytes to one channel register with a full load of another, then checks that the first register ends with only the bytes of its own later complete load. The one-cycle gap between the strobe and the transfer is checked by sampling the exported word on both sides of that edge.

// File: rtl/dds_regbank_pkg.sv
package dds_regbank_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADR_GATE = 0;
  localparam int unsigned ADR_CFGA = 1;
  localparam int unsigned ADR_CFGB = 2;
  localparam int unsigned ADR_CHAN = 4;
  localparam int unsigned CFGA_W   = 24;
  localparam int unsigned CFGB_W   = 16;
  localparam logic [7:0]  GATE_RST = 8'hF0;
endpackage

// File: rtl/regbank_asm.sv
// Byte assembler: gathers consecutive writes to one address, MSB first.
module regbank_asm #(
  parameter int ADDR_W = 8,
  parameter int MAXB   = 4,
  localparam int CNT_W = $clog2(MAXB + 1),
  localparam int DW    = MAXB * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [CNT_W-1:0]  len,
  output logic              commit,
  output logic [DW-1:0]     word
);
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [DW-9:0]     acc;
  logic              cont;

  always_comb begin
    cont   = (cnt != '0) && (addr == cur_addr);
    cnt_nx = cont ? cnt + CNT_W'(1) : CNT_W'(1);
    word   = cont ? {acc, wdata} : {{(DW-8){1'b0}}, wdata};
    commit = wr_en && (len != '0) && (cnt_nx == len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cur_addr <= '0;
      acc      <= '0;
    end else if (wr_en) begin
      if (len == '0 || commit) begin
        cnt <= '0;
      end else begin
        cnt      <= cnt_nx;
        acc      <= word[DW-9:0];
        cur_addr <= addr;
      end
    end
  end

  // R6: the byte count never reaches the longest register length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    commit |=> (cnt == '0));
endmodule

// File: rtl/regbank_glob.sv
// Global registers: gate bits act at once, the rest are double buffered.
module regbank_glob #(
  parameter int NCH    = 2,
  parameter int CFGA_W = 24,
  parameter int CFGB_W = 16,
  parameter logic [7:0] GATE_RST = 8'hF0,
  localparam int MODE_W = 8 - NCH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              wr_gate,
  input  logic              wr_cfga,
  input  logic              wr_cfgb,
  input  logic [CFGA_W-1:0] wdat,
  output logic [NCH-1:0]    chan_en,
  output logic [MODE_W-1:0] mode_shd,
  output logic [MODE_W-1:0] mode_act,
  output logic [CFGA_W-1:0] cfga_shd,
  output logic [CFGA_W-1:0] cfga_act,
  output logic [CFGB_W-1:0] cfgb_shd,
  output logic [CFGB_W-1:0] cfgb_act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en  <= GATE_RST[7 -: NCH];
      mode_shd <= GATE_RST[MODE_W-1:0];
      cfga_shd <= '0;
      cfgb_shd <= '0;
    end else begin
      if (wr_gate) begin
        chan_en  <= wdat[7 -: NCH];
        mode_shd <= wdat[MODE_W-1:0];
      end
      if (wr_cfga) cfga_shd <= wdat;
      if (wr_cfgb) cfgb_shd <= wdat[CFGB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_act <= GATE_RST[MODE_W-1:0];
      cfga_act <= '0;
      cfgb_act <= '0;
    end else if (upd) begin
      mode_act <= mode_shd;
      cfga_act <= cfga_shd;
      cfgb_act <= cfgb_shd;
    end
  end

  // R3: active copies hold while no update is pending
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(cfga_act) && $stable(cfgb_act) && $stable(mode_act)));
  // R4: an update copies the shadow seen at that edge
  p_copy_r4: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cfga_act == $past(cfga_shd) && cfgb_act == $past(cfgb_shd)
             && mode_act == $past(mode_shd)));
endmodule

// File: rtl/regbank_chan.sv
// One channel's register set: shadow memory plus active copy.
module regbank_chan #(
  parameter int NREGS = 2,
  parameter int REG_W = 32,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             wr,
  input  logic [IDX_W-1:0] widx,
  input  logic [REG_W-1:0] wdat,
  output logic [REG_W-1:0] shd [NREGS],
  output logic [REG_W-1:0] act [NREGS]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREGS; r++) shd[r] <= '0;
    end else if (wr) begin
      shd[widx] <= wdat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREGS; r++) act[r] <= '0;
    end else if (upd) begin
      for (int r = 0; r < NREGS; r++) act[r] <= shd[r];
    end
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_chk
    // R5: a gated-off channel keeps its shadow
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(shd[r]));
  end
endmodule

// File: rtl/dds_regbank.sv
module dds_regbank
  import dds_regbank_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int NCH_REGS = 2,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 8,
  localparam int SEL_W   = $clog2(REG_W / 8),
  localparam int MODE_W  = 8 - NCH
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                wdata,
  input  logic                      rd_en,
  input  logic                      rd_active,
  input  logic [SEL_W-1:0]          rd_byte,
  input  logic                      io_update,
  output logic [7:0]                rdata,
  output logic                      rd_valid,
  output logic                      rd_err,
  output logic [NCH-1:0]            chan_en,
  output logic [MODE_W-1:0]         mode_act,
  output logic [CFGA_W-1:0]         fr1_act,
  output logic [CFGB_W-1:0]         fr2_act,
  output logic [NCH*NCH_REGS*REG_W-1:0] ch_act
);
  localparam int MAXB  = REG_W / 8;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int IDX_W = (NCH_REGS > 1) ? $clog2(NCH_REGS) : 1;
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;

  logic              upd_q;
  logic [CNT_W-1:0]  len;
  logic              commit;
  logic [REG_W-1:0]  word;
  logic [ADDR_W-1:0] ch_off;
  logic              is_ch, is_gate, is_cfga, is_cfgb;
  logic [IDX_W-1:0]  ch_idx;
  logic [MODE_W-1:0] mode_shd;
  logic [CFGA_W-1:0] cfga_shd;
  logic [CFGB_W-1:0] cfgb_shd;
  logic [REG_W-1:0]  ch_shd_w [NCH][NCH_REGS];
  logic [REG_W-1:0]  ch_act_w [NCH][NCH_REGS];
  logic [CH_W-1:0]   sel_ch;
  logic [REG_W-1:0]  rd_word;
  logic              rd_bad;

  // Address decode and register length in bytes
  always_comb begin
    is_gate = (addr == ADDR_W'(ADR_GATE));
    is_cfga = (addr == ADDR_W'(ADR_CFGA));
    is_cfgb = (addr == ADDR_W'(ADR_CFGB));
    ch_off  = addr - ADDR_W'(ADR_CHAN);
    is_ch   = (ch_off < ADDR_W'(NCH_REGS));
    ch_idx  = ch_off[IDX_W-1:0];
    len     = '0;
    if (is_gate)      len = CNT_W'(1);
    else if (is_cfga) len = CNT_W'(CFGA_W / 8);
    else if (is_cfgb) len = CNT_W'(CFGB_W / 8);
    else if (is_ch)   len = CNT_W'(MAXB);
  end

  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= io_update;
  end

  regbank_asm #(.ADDR_W(ADDR_W), .MAXB(MAXB)) u_asm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .len(len), .commit(commit), .word(word)
  );

  regbank_glob #(.NCH(NCH), .CFGA_W(CFGA_W), .CFGB_W(CFGB_W),
                 .GATE_RST(GATE_RST)) u_glob (
    .clk(clk), .rst(rst), .upd(upd_q),
    .wr_gate(commit && is_gate), .wr_cfga(commit && is_cfga),
    .wr_cfgb(commit && is_cfgb), .wdat(word[CFGA_W-1:0]),
    .chan_en(chan_en), .mode_shd(mode_shd), .mode_act(mode_act),
    .cfga_shd(cfga_shd), .cfga_act(fr1_act),
    .cfgb_shd(cfgb_shd), .cfgb_act(fr2_act)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    regbank_chan #(.NREGS(NCH_REGS), .REG_W(REG_W)) u_chan (
      .clk(clk), .rst(rst), .upd(upd_q),
      .wr(commit && is_ch && chan_en[c]), .widx(ch_idx), .wdat(word),
      .shd(ch_shd_w[c]), .act(ch_act_w[c])
    );
    for (genvar r = 0; r < NCH_REGS; r++) begin : g_out
      assign ch_act[(c*NCH_REGS + r)*REG_W +: REG_W] = ch_act_w[c][r];
    end
  end

  // Read path
  always_comb begin
    sel_ch = '0;
    for (int c = 0; c < NCH; c++) if (chan_en[c]) sel_ch = CH_W'(c);
  end

  always_comb begin
    rd_word = '0;
    rd_bad  = 1'b0;
    if (is_gate) begin
      rd_word = REG_W'({chan_en, rd_active ? mode_act : mode_shd});
    end else if (is_cfga) begin
      rd_word = REG_W'(rd_active ? fr1_act : cfga_shd);
    end else if (is_cfgb) begin
      rd_word = REG_W'(rd_active ? fr2_act : cfgb_shd);
    end else if (is_ch) begin
      if ($onehot(chan_en))
        rd_word = rd_active ? ch_act_w[sel_ch][ch_idx] : ch_shd_w[sel_ch][ch_idx];
      else
        rd_bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_err   <= rd_en && rd_bad;
      rdata    <= rd_en ? rd_word[rd_byte*8 +: 8] : 8'h00;
    end
  end

  // R2: gate bits follow a gate-register write at the next edge
  p_gate_now_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_gate) |=> (chan_en == $past(wdata[7 -: NCH])));
  // R8: every read request yields valid data one cycle later
  p_rd_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R9: an error read carries zero data
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_valid && rdata == 8'h00));
endmodule

// File: tb/sim_dds_regbank.sv
module sim_dds_regbank;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_N = 2'd0, OP_W = 2'd1, OP_R = 2'd2, OP_U = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;
    logic [7:0] data;
    logic       src;
    logic [1:0] sel;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t VEC [NV] = '{
    '{OP_W, 8'h00, 8'h40, 1'b0, 2'd0, 8'h00, 4'd2},  // gate ch0 only
    '{OP_W, 8'h04, 8'hDE, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h04, 8'hAD, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h04, 8'hBE, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h04, 8'hEF, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h00, 8'h80, 1'b0, 2'd0, 8'h00, 4'd2},  // gate ch1 only
    '{OP_W, 8'h04, 8'h01, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h04, 8'h02, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h04, 8'h03, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h04, 8'h04, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_R, 8'h04, 8'h00, 1'b0, 2'd3, 8'h01, 4'd5},  // R5 ch1 shadow
    '{OP_R, 8'h04, 8'h00, 1'b0, 2'd0, 8'h04, 4'd8},  // R8 byte 0
    '{OP_R, 8'h04, 8'h00, 1'b1, 2'd3, 8'h00, 4'd3},  // R3 active untouched
    '{OP_W, 8'h00, 8'h40, 1'b0, 2'd0, 8'h00, 4'd2},
    '{OP_R, 8'h04, 8'h00, 1'b0, 2'd3, 8'hDE, 4'd5},  // R5 ch0 kept
    '{OP_R, 8'h04, 8'h00, 1'b0, 2'd0, 8'hEF, 4'd6},
    '{OP_U, 8'h00, 8'h00, 1'b0, 2'd0, 8'h00, 4'd4},
    '{OP_N, 8'h00, 8'h00, 1'b0, 2'd0, 8'h00, 4'd4},
    '{OP_R, 8'h04, 8'h00, 1'b1, 2'd2, 8'hAD, 4'd4},  // R4 active now
    '{OP_W, 8'h01, 8'h11, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h01, 8'h22, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h01, 8'h33, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_R, 8'h01, 8'h00, 1'b0, 2'd2, 8'h11, 4'd6},  // R6 MSB first
    '{OP_R, 8'h01, 8'h00, 1'b0, 2'd0, 8'h33, 4'd6},
    '{OP_R, 8'h01, 8'h00, 1'b1, 2'd0, 8'h00, 4'd3},  // R3
    '{OP_W, 8'h02, 8'hA5, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_W, 8'h02, 8'h5A, 1'b0, 2'd0, 8'h00, 4'd6},
    '{OP_R, 8'h02, 8'h00, 1'b0, 2'd1, 8'hA5, 4'd6},  // R6 two bytes
    '{OP_W, 8'h05, 8'h12, 1'b0, 2'd0, 8'h00, 4'd7},  // partial load
    '{OP_W, 8'h05, 8'h34, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_W, 8'h04, 8'h99, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_W, 8'h04, 8'hAA, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_W, 8'h04, 8'hBB, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_W, 8'h04, 8'hCC, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_W, 8'h05, 8'h55, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_W, 8'h05, 8'h66, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_W, 8'h05, 8'h77, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_W, 8'h05, 8'h88, 1'b0, 2'd0, 8'h00, 4'd7},
    '{OP_R, 8'h05, 8'h00, 1'b0, 2'd3, 8'h55, 4'd7},  // R7 restart
    '{OP_R, 8'h05, 8'h00, 1'b0, 2'd0, 8'h88, 4'd7},
    '{OP_R, 8'h04, 8'h00, 1'b0, 2'd3, 8'h99, 4'd7},
    '{OP_W, 8'h03, 8'hFF, 1'b0, 2'd0, 8'h00, 4'd10},
    '{OP_W, 8'h06, 8'hFF, 1'b0, 2'd0, 8'h00, 4'd10},
    '{OP_R, 8'h03, 8'h00, 1'b0, 2'd0, 8'h00, 4'd10}, // R10 hole
    '{OP_R, 8'h06, 8'h00, 1'b1, 2'd0, 8'h00, 4'd10},
    '{OP_R, 8'h02, 8'h00, 1'b0, 2'd0, 8'h5A, 4'd10}, // R10 untouched
    '{OP_W, 8'h00, 8'h45, 1'b0, 2'd0, 8'h00, 4'd2},
    '{OP_R, 8'h00, 8'h00, 1'b0, 2'd0, 8'h45, 4'd2},  // R2 readback
    '{OP_R, 8'h00, 8'h00, 1'b1, 2'd0, 8'h40, 4'd3},  // R3 mode waits
    '{OP_U, 8'h00, 8'h00, 1'b0, 2'd0, 8'h00, 4'd4},
    '{OP_N, 8'h00, 8'h00, 1'b0, 2'd0, 8'h00, 4'd4},
    '{OP_R, 8'h00, 8'h00, 1'b1, 2'd0, 8'h45, 4'd4},  // R4
    '{OP_R, 8'h00, 8'h00, 1'b0, 2'd1, 8'h00, 4'd8}   // R8 beyond width
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0, rd_active = 1'b0, io_update = 1'b0;
  logic [7:0]   addr = '0, wdata = '0;
  logic [1:0]   rd_byte = '0;
  logic [7:0]   rdata;
  logic         rd_valid, rd_err;
  logic [1:0]   chan_en;
  logic [5:0]   mode_act;
  logic [23:0]  fr1_act;
  logic [15:0]  fr2_act;
  logic [127:0] ch_act;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_regbank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rd_active(rd_active), .rd_byte(rd_byte),
    .io_update(io_update), .rdata(rdata), .rd_valid(rd_valid),
    .rd_err(rd_err), .chan_en(chan_en), .mode_act(mode_act),
    .fr1_act(fr1_act), .fr2_act(fr2_act), .ch_act(ch_act)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, returns at the following negedge
  task automatic cyc(input logic [1:0] o, input logic [7:0] a, input logic [7:0] d,
                     input logic s, input logic [1:0] sl);
    wr_en     = (o == OP_W);
    rd_en     = (o == OP_R);
    io_update = (o == OP_U);
    addr      = a;
    wdata     = d;
    rd_active = s;
    rd_byte   = sl;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; io_update = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 chan_en", 32'(chan_en), 32'h3);
    chk("R1 mode_act", 32'(mode_act), 32'h30);
    chk("R1 fr1_act", 32'(fr1_act), 32'h0);
    chk("R1 fr2_act", 32'(fr2_act), 32'h0);
    chk("R1 ch_act", 32'(ch_act != '0), 32'h0);
    chk("R1 rd flags", 32'({rd_valid, rd_err}), 32'h0);
    cyc(OP_R, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R1 gate shadow", 32'(rdata), 32'hF0);
    cyc(OP_R, 8'h00, 8'h00, 1'b1, 2'd0);
    chk("R1 gate active", 32'(rdata), 32'hF0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].src, VEC[i].sel);
      if (VEC[i].op == OP_R) begin
        chk($sformatf("R%0d vector %0d rdata", VEC[i].req, i), 32'(rdata), 32'(VEC[i].exp));
        chk($sformatf("R8 vector %0d valid", i), 32'({rd_valid, rd_err}), 32'h2);
      end
    end

    // R2: gates open at once, no update
    cyc(OP_W, 8'h00, 8'hC0, 1'b0, 2'd0);
    chk("R2 gates immediate", 32'(chan_en), 32'h3);
    // R5: broadcast to both open channels
    cyc(OP_W, 8'h05, 8'hCA, 1'b0, 2'd0);
    cyc(OP_W, 8'h05, 8'hFE, 1'b0, 2'd0);
    cyc(OP_W, 8'h05, 8'hF0, 1'b0, 2'd0);
    cyc(OP_W, 8'h05, 8'h0D, 1'b0, 2'd0);
    cyc(OP_U, 8'h00, 8'h00, 1'b0, 2'd0);
    cyc(OP_N, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R5 ch0 reg1", ch_act[63:32], 32'hCAFEF00D);
    chk("R5 ch1 reg1", ch_act[127:96], 32'hCAFEF00D);
    chk("R5 ch0 reg0", ch_act[31:0], 32'h99AABBCC);
    chk("R5 ch1 reg0", ch_act[95:64], 32'h01020304);
    // R9: both gates open
    cyc(OP_R, 8'h04, 8'h00, 1'b0, 2'd0);
    chk("R9 both open", 32'({rdata, rd_valid, rd_err}), 32'h003);
    cyc(OP_N, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R9 one-cycle err", 32'(rd_err), 32'h0);
    // R9: no gate open
    cyc(OP_W, 8'h00, 8'h00, 1'b0, 2'd0);
    cyc(OP_R, 8'h05, 8'h00, 1'b1, 2'd3);
    chk("R9 none open", 32'({rdata, rd_valid, rd_err}), 32'h003);
    // R3 / R4: transfer lands one edge after the strobe is sampled
    cyc(OP_W, 8'h02, 8'h12, 1'b0, 2'd0);
    cyc(OP_W, 8'h02, 8'h34, 1'b0, 2'd0);
    chk("R3 fr2 waits", 32'(fr2_act), 32'hA55A);
    chk("R3 fr1 active", 32'(fr1_act), 32'h112233);
    cyc(OP_U, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R4 not yet", 32'(fr2_act), 32'hA55A);
    cyc(OP_N, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R4 transferred", 32'(fr2_act), 32'h1234);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule